// File: doc/BRIEF.md
# Descriptor Chain DMA Sequencer

This block walks a linked list of 16-byte command descriptors held in system memory. Each descriptor is fetched from the address in the command pointer and decoded. It is then executed as one of these: moving bytes from memory to a device stream, moving bytes from the stream into memory, a sized word store or load against memory, a no-op, or a stop. When a descriptor finishes, the sequencer writes the channel status back into the descriptor and may raise an interrupt. It then either steps to the following descriptor or jumps to a target carried inside the descriptor.

Memory is reached through one 32-bit request/acknowledge port with byte strobes. The device side is a byte stream with valid/ready in each direction. A register unit supplies run, pause and wake controls and pointer writes, and reads back the flags. An external condition evaluator supplies three match bits. Each descriptor's own interrupt, branch and wait policy applies those bits.

Top module: `desc_chain_seq`

## Requirements
- R1: Descriptors are little-endian 32-bit words at pointer offsets 0, 4, 8 and 12. Word 0 holds the byte count in bits 15:0 and the command in bits 31:16. Word 1 is the data address, word 2 the command-dependent word, and word 3 has the residual count in bits 15:0 and the transfer status in bits 31:16. Command bits 15:12 give the opcode (0 out-more, 1 out-last, 2 in-more, 3 in-last, 4 store, 5 load, 6 no-op, 7 stop), bits 10:8 the key, bits 5:4 the interrupt policy, bits 3:2 the branch policy and bits 1:0 the wait policy. A descriptor is fetched only while run and active are both set and pause is low.
- R2: Opcodes 0 and 1 send the requested number of bytes, read in ascending address order from the data address, on the output stream. Opcode 1 marks the final byte with the end flag.
- R3: Opcodes 2 and 3 write the requested number of bytes from the input stream to ascending addresses starting at the data address.
- R4: On completion the status word is written into bits 31:16 of descriptor word 3. Its layout is run bit 15, pause 14, wake 12, dead 11, active 10, branch-taken 8 and device status 7:0. Data transfers also write zero to the residual count; all other opcodes leave it unchanged.
- R5: A store keeps only bits 2:0 of the count. Bit 2 selects 4 bytes at an address aligned down to 4. Otherwise bit 1 selects 2 bytes at an address aligned down to 2. Otherwise the size is 1 byte. The value is the top 4, 2 or 1 bytes of the command-dependent word, written little-endian.
- R6: A load uses the same sizing. It places the fetched bytes in the top of the command-dependent word, keeps the lower bits, and writes the updated word back to descriptor word 2.
- R7: A policy code of 0 means never, 1 means when the condition is 1, 2 means when it is 0, and 3 means always. A taken branch loads the pointer from the command-dependent word aligned down to 16 and sets branch-taken. Otherwise the pointer advances by 16 and branch-taken clears. Loads and stores always advance.
- R8: The interrupt output pulses for one cycle when the interrupt policy is met at completion.
- R9: While the wait policy is met, the descriptor stalls before write-back, and the pointer stays where it is.
- R10: A stop clears active and dead, writes nothing, and leaves the pointer on the stop descriptor.
- R11: The channel is killed (dead set, active cleared, interrupt pulsed, pointer unchanged) in three cases: a transfer with a key above 3 or a data address of zero, a load or store whose key is 5 or 7 (keys below 5 count as system space 6), and an opcode above 7.
- R12: A pointer write takes effect only while run and active are both low, and is aligned down to 16.
- R13: A wake pulse sets active and the wake flag, and the wake flag clears when a descriptor fetch begins. Pause clears active whenever the sequencer sits between descriptors.
- R14: A rising run sets active and clears dead. A falling run clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| runIn | input | 1 | Run control level |
| pauseIn | input | 1 | Pause control level |
| wakeIn | input | 1 | Wake pulse |
| ptrWrite | input | 1 | Command pointer write strobe |
| ptrData | input | ADDR_W | Command pointer write value |
| devStat | input | 8 | Device status byte carried in the status word |
| intrCond | input | 1 | Interrupt condition match |
| branchCond | input | 1 | Branch condition match |
| waitCond | input | 1 | Wait condition match |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory write enable |
| memAddr | output | ADDR_W | Word-aligned memory byte address |
| memWdata | output | 32 | Memory write data |
| memStrb | output | 4 | Memory byte strobes |
| memAck | input | 1 | Memory acknowledge, read data valid |
| memRdata | input | 32 | Memory read data |
| outValid | output | 1 | Output stream byte valid |
| outData | output | 8 | Output stream byte |
| outLast | output | 1 | Output stream end marker |
| outReady | input | 1 | Output stream ready |
| inValid | input | 1 | Input stream byte valid |
| inData | input | 8 | Input stream byte |
| inReady | output | 1 | Input stream ready |
| irq | output | 1 | Interrupt pulse |
| chActive | output | 1 | Active flag |
| chDead | output | 1 | Dead flag |
| chBt | output | 1 | Branch-taken flag |
| chWake | output | 1 | Wake flag |
| cmdPtr | output | ADDR_W | Command pointer |

## Verification
The assertions rely on two input properties. The memory side and the stream sink are expected to see a request held steady until it is acknowledged. Run and the active flag are expected to be settled values, so the pointer-lock check can compare them against pointer movement from one cycle to the next. The bench acknowledges memory in the same cycle as the request and drives every control level on the falling edge. It toggles output ready in a fixed pattern so that stalls occur partway through a transfer. The input stream is only offered bytes when a descriptor is ready to take them.

// File: rtl/desc_chain_pkg.sv
package desc_chain_pkg;
  localparam int DESC_BYTES = 16;
  localparam int CNT_W      = 16;

  localparam logic [3:0] OP_OUT_LAST = 4'd1;
  localparam logic [3:0] OP_STORE    = 4'd4;
  localparam logic [3:0] OP_LOAD     = 4'd5;
  localparam logic [3:0] OP_NOP      = 4'd6;
  localparam logic [3:0] OP_STOP     = 4'd7;

  typedef enum logic [2:0] {MS_W0, MS_W1, MS_W2, MS_BYTE, MS_WORD, MS_DEP, MS_STAT} memsel_e;

  typedef struct packed {
    logic    capW0, capW1, capW2;
    logic    capRd, capIn, capLoad;
    logic    step, goNext, goBranch;
    memsel_e sel;
  } ctl_t;

  typedef struct packed {
    logic [3:0] op;
    logic [2:0] key;
    logic [1:0] intrPol, brPol, waitPol;
    logic       addrZero, cntZero, lastByte;
  } info_t;

  function automatic logic polHit(input logic [1:0] pol, input logic cond);
    case (pol)
      2'd0:    return 1'b0;
      2'd1:    return cond;
      2'd2:    return !cond;
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/desc_chain_dp.sv
module desc_chain_dp import desc_chain_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic              ptrWrEn,
  input  logic [ADDR_W-1:0] ptrData,
  input  logic [15:0]       statWord,
  input  logic [31:0]       memRdata,
  input  logic [7:0]        inData,
  output logic [ADDR_W-1:0] cmdPtr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [3:0]        memStrb,
  output logic [7:0]        outData,
  output info_t             info
);
  localparam logic [ADDR_W-1:0] ALIGN16 = ~ADDR_W'(DESC_BYTES - 1);

  logic [CNT_W-1:0]  reqCount, byteIdx;
  logic [3:0]        op;
  logic [2:0]        key;
  logic [5:0]        pol;
  logic [ADDR_W-1:0] dataAddr;
  logic [31:0]       cmdDep;
  logic [7:0]        byteBuf;

  logic [ADDR_W-1:0] byteAddr, wordAddr;
  logic              sz4, sz2;
  logic [4:0]        byteSh, wordSh;
  logic [31:0]       storeVal, loadVal;
  logic [3:0]        sizeMask;

  assign byteAddr = dataAddr + ADDR_W'(byteIdx);
  assign byteSh   = {byteAddr[1:0], 3'b000};
  assign sz4      = reqCount[2];
  assign sz2      = !reqCount[2] && reqCount[1];
  assign wordAddr = sz4 ? (dataAddr & ~ADDR_W'(3)) : sz2 ? (dataAddr & ~ADDR_W'(1)) : dataAddr;
  assign wordSh   = {wordAddr[1:0], 3'b000};
  assign storeVal = sz4 ? cmdDep : sz2 ? {16'h0, cmdDep[31:16]} : {24'h0, cmdDep[31:24]};
  assign sizeMask = sz4 ? 4'hF : sz2 ? 4'h3 : 4'h1;
  assign loadVal  = memRdata >> wordSh;

  always_comb begin
    memAddr  = cmdPtr;
    memWdata = '0;
    memStrb  = 4'h0;
    case (ctl.sel)
      MS_W1:   memAddr = cmdPtr + ADDR_W'(4);
      MS_W2:   memAddr = cmdPtr + ADDR_W'(8);
      MS_BYTE: begin
        memAddr  = byteAddr & ~ADDR_W'(3);
        memWdata = {4{byteBuf}};
        memStrb  = 4'h1 << byteAddr[1:0];
      end
      MS_WORD: begin
        memAddr  = wordAddr & ~ADDR_W'(3);
        memWdata = storeVal << wordSh;
        memStrb  = sizeMask << wordAddr[1:0];
      end
      MS_DEP: begin
        memAddr  = cmdPtr + ADDR_W'(8);
        memWdata = cmdDep;
        memStrb  = 4'hF;
      end
      MS_STAT: begin
        memAddr  = cmdPtr + ADDR_W'(12);
        memWdata = {statWord, 16'h0};
        memStrb  = (op[3:2] == 2'b00) ? 4'hF : 4'hC;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdPtr <= '0; reqCount <= '0; byteIdx <= '0; op <= '0; key <= '0;
      pol <= '0; dataAddr <= '0; cmdDep <= '0; byteBuf <= '0;
    end else begin
      if (ptrWrEn)      cmdPtr <= ptrData & ALIGN16;
      if (ctl.goNext)   cmdPtr <= cmdPtr + ADDR_W'(DESC_BYTES);
      if (ctl.goBranch) cmdPtr <= ADDR_W'(cmdDep) & ALIGN16;
      if (ctl.capW0) begin
        reqCount <= memRdata[15:0];
        op       <= memRdata[31:28];
        key      <= memRdata[26:24];
        pol      <= memRdata[21:16];
        byteIdx  <= '0;
      end
      if (ctl.capW1)  dataAddr <= ADDR_W'(memRdata);
      if (ctl.capW2)  cmdDep   <= memRdata;
      if (ctl.capRd)  byteBuf  <= 8'(memRdata >> byteSh);
      if (ctl.capIn)  byteBuf  <= inData;
      if (ctl.step)   byteIdx  <= byteIdx + 1'b1;
      if (ctl.capLoad)
        cmdDep <= sz4 ? loadVal
                : sz2 ? {loadVal[15:0], cmdDep[15:0]}
                      : {loadVal[7:0], cmdDep[23:0]};
    end
  end

  assign outData       = byteBuf;
  assign info.op       = op;
  assign info.key      = key;
  assign info.intrPol  = pol[5:4];
  assign info.brPol    = pol[3:2];
  assign info.waitPol  = pol[1:0];
  assign info.addrZero = (dataAddr == '0);
  assign info.cntZero  = (reqCount == '0);
  assign info.lastByte = (byteIdx == reqCount - 1'b1);
endmodule

// File: rtl/desc_chain_ctrl.sv
module desc_chain_ctrl import desc_chain_pkg::*; (
  input  logic        clk,
  input  logic        rstN,
  input  logic        runIn,
  input  logic        pauseIn,
  input  logic        wakeIn,
  input  logic [7:0]  devStat,
  input  logic        intrCond,
  input  logic        branchCond,
  input  logic        waitCond,
  input  logic        memAck,
  input  logic        outReady,
  input  logic        inValid,
  input  info_t       info,
  output ctl_t        ctl,
  output logic        memReq,
  output logic        memWe,
  output logic        outValid,
  output logic        outLast,
  output logic        inReady,
  output logic        irq,
  output logic        chActive,
  output logic        chDead,
  output logic        chBt,
  output logic        chWake,
  output logic [15:0] statWord
);
  typedef enum logic [3:0] {S_IDLE, S_F0, S_F1, S_F2, S_DEC, S_ORD, S_OPUSH, S_IPULL,
                            S_IWR, S_WMEM, S_WAIT, S_WDEP, S_WSTAT, S_ADV} state_e;
  state_e st;
  logic   runQ, isXfer, isWord, killNow, waitHit, intrHit, brHit;

  assign isXfer  = (info.op[3:2] == 2'b00);
  assign isWord  = (info.op == OP_STORE) || (info.op == OP_LOAD);
  assign killNow = info.op[3]
                 || (isXfer && (info.key > 3'd3 || info.addrZero))
                 || (isWord && (info.key == 3'd5 || info.key == 3'd7));
  assign waitHit = polHit(info.waitPol, waitCond);
  assign intrHit = polHit(info.intrPol, intrCond);
  assign brHit   = polHit(info.brPol, branchCond);
  assign statWord = {runIn, pauseIn, 1'b0, chWake, chDead, chActive, 1'b0, chBt, devStat};

  always_comb begin
    ctl = '0;
    ctl.sel = MS_W0;
    memReq = 1'b0; memWe = 1'b0; outValid = 1'b0; outLast = 1'b0; inReady = 1'b0;
    case (st)
      S_F0:    begin memReq = 1'b1; ctl.capW0 = memAck; end
      S_F1:    begin memReq = 1'b1; ctl.sel = MS_W1; ctl.capW1 = memAck; end
      S_F2:    begin memReq = 1'b1; ctl.sel = MS_W2; ctl.capW2 = memAck; end
      S_ORD:   begin memReq = 1'b1; ctl.sel = MS_BYTE; ctl.capRd = memAck; end
      S_OPUSH: begin
        outValid = 1'b1;
        outLast  = (info.op == OP_OUT_LAST) && info.lastByte;
        ctl.step = outReady;
      end
      S_IPULL: begin inReady = 1'b1; ctl.capIn = inValid; end
      S_IWR:   begin memReq = 1'b1; memWe = 1'b1; ctl.sel = MS_BYTE; ctl.step = memAck; end
      S_WMEM:  begin
        memReq = 1'b1; memWe = (info.op == OP_STORE); ctl.sel = MS_WORD;
        ctl.capLoad = memAck && (info.op == OP_LOAD);
      end
      S_WDEP:  begin memReq = 1'b1; memWe = 1'b1; ctl.sel = MS_DEP; end
      S_WSTAT: begin memReq = 1'b1; memWe = 1'b1; ctl.sel = MS_STAT; end
      S_ADV:   begin
        ctl.goBranch = !isWord && brHit;
        ctl.goNext   = isWord || !brHit;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= S_IDLE; runQ <= 1'b0; irq <= 1'b0;
      chActive <= 1'b0; chDead <= 1'b0; chBt <= 1'b0; chWake <= 1'b0;
    end else begin
      irq  <= 1'b0;
      runQ <= runIn;
      case (st)
        S_IDLE:  if (runIn && chActive && !pauseIn) begin st <= S_F0; chWake <= 1'b0; end
        S_F0:    if (memAck) st <= S_F1;
        S_F1:    if (memAck) st <= S_F2;
        S_F2:    if (memAck) st <= S_DEC;
        S_DEC: begin
          if (info.op == OP_STOP) begin
            chActive <= 1'b0; chDead <= 1'b0; st <= S_IDLE;
          end else if (killNow) begin
            chDead <= 1'b1; chActive <= 1'b0; irq <= 1'b1; st <= S_IDLE;
          end else if (info.op == OP_NOP || (isXfer && info.cntZero)) st <= S_WAIT;
          else if (isWord)     st <= S_WMEM;
          else if (info.op[1]) st <= S_IPULL;
          else                 st <= S_ORD;
        end
        S_ORD:   if (memAck) st <= S_OPUSH;
        S_OPUSH: if (outReady) st <= info.lastByte ? S_WAIT : S_ORD;
        S_IPULL: if (inValid) st <= S_IWR;
        S_IWR:   if (memAck) st <= info.lastByte ? S_WAIT : S_IPULL;
        S_WMEM:  if (memAck) st <= S_WAIT;
        S_WAIT:  if (!waitHit) st <= (info.op == OP_LOAD) ? S_WDEP : S_WSTAT;
        S_WDEP:  if (memAck) st <= S_WSTAT;
        S_WSTAT: if (memAck) st <= S_ADV;
        S_ADV: begin
          irq  <= intrHit;
          chBt <= !isWord && brHit;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      if (runIn && !runQ) begin chActive <= 1'b1; chDead <= 1'b0; end
      else if (!runIn && runQ) begin chActive <= 1'b0; chDead <= 1'b0; end
      if (wakeIn) begin chActive <= 1'b1; chWake <= 1'b1; end
      if (pauseIn && st == S_IDLE) chActive <= 1'b0;
    end
  end
endmodule

// File: rtl/desc_chain_seq.sv
module desc_chain_seq import desc_chain_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runIn,
  input  logic              pauseIn,
  input  logic              wakeIn,
  input  logic              ptrWrite,
  input  logic [ADDR_W-1:0] ptrData,
  input  logic [7:0]        devStat,
  input  logic              intrCond,
  input  logic              branchCond,
  input  logic              waitCond,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [3:0]        memStrb,
  input  logic              memAck,
  input  logic [31:0]       memRdata,
  output logic              outValid,
  output logic [7:0]        outData,
  output logic              outLast,
  input  logic              outReady,
  input  logic              inValid,
  input  logic [7:0]        inData,
  output logic              inReady,
  output logic              irq,
  output logic              chActive,
  output logic              chDead,
  output logic              chBt,
  output logic              chWake,
  output logic [ADDR_W-1:0] cmdPtr
);
  ctl_t        ctl;
  info_t       info;
  logic [15:0] statWord;
  logic        ptrWrEn;

  assign ptrWrEn = ptrWrite && !runIn && !chActive;

  desc_chain_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .runIn(runIn), .pauseIn(pauseIn), .wakeIn(wakeIn),
    .devStat(devStat), .intrCond(intrCond), .branchCond(branchCond), .waitCond(waitCond),
    .memAck(memAck), .outReady(outReady), .inValid(inValid), .info(info), .ctl(ctl),
    .memReq(memReq), .memWe(memWe), .outValid(outValid), .outLast(outLast),
    .inReady(inReady), .irq(irq), .chActive(chActive), .chDead(chDead), .chBt(chBt),
    .chWake(chWake), .statWord(statWord)
  );

  desc_chain_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .ptrWrEn(ptrWrEn), .ptrData(ptrData),
    .statWord(statWord), .memRdata(memRdata), .inData(inData), .cmdPtr(cmdPtr),
    .memAddr(memAddr), .memWdata(memWdata), .memStrb(memStrb), .outData(outData),
    .info(info)
  );
endmodule

// File: rtl/desc_chain_chk.sv
module desc_chain_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              runIn,
  input logic              memReq,
  input logic              memAck,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              outValid,
  input logic              outReady,
  input logic [7:0]        outData,
  input logic              outLast,
  input logic              irq,
  input logic              chDead,
  input logic              chActive,
  input logic [ADDR_W-1:0] cmdPtr
);
  // R1
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));
  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outLast));
  // R2
  last_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);
  // R11
  kill_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chDead) |-> irq);
  // R12
  ptr_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(runIn) && !$past(chActive)) |-> $stable(cmdPtr));
endmodule

bind desc_chain_seq desc_chain_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_desc_chain_seq.sv
module sim_desc_chain_seq;
  logic        clk = 1'b0, rstN = 1'b0;
  logic        runIn = 0, pauseIn = 0, wakeIn = 0, ptrWrite = 0;
  logic [31:0] ptrData = '0;
  logic [7:0]  devStat = 8'h5A;
  logic        intrCond = 0, branchCond = 0, waitCond = 0;
  logic        memReq, memWe, memAck, outValid, outLast, inValid, inReady;
  logic        irq, chActive, chDead, chBt, chWake, outReady = 1'b1;
  logic [31:0] memAddr, memWdata, memRdata, cmdPtr;
  logic [3:0]  memStrb;
  logic [7:0]  outData, inData;
  logic [31:0] mem [0:255];
  logic [7:0]  inArr [0:3];
  int          inIdx = 0, checks = 0, errors = 0, irqCnt = 0;
  logic [8:0]  expQ[$];

  always #5 clk = ~clk;

  desc_chain_seq u0 (.*);

  assign memAck   = memReq;
  assign memRdata = mem[memAddr[9:2]];
  assign inValid  = (inIdx < 3);
  assign inData   = inArr[inIdx[1:0]];

  always @(posedge clk) begin
    if (memReq && memWe)
      for (int b = 0; b < 4; b++)
        if (memStrb[b]) mem[memAddr[9:2]][8*b +: 8] <= memWdata[8*b +: 8];
    if (inValid && inReady) inIdx <= inIdx + 1;
  end

  initial begin
    int k = 0;
    forever begin @(posedge clk); #2; outReady = (k % 3) != 0; k++; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // reference comparison of the output stream, beat by beat
  always @(negedge clk) if (rstN) begin
    if (irq) irqCnt++;
    if (outValid && outReady) begin
      if (expQ.size() == 0) chk("R2 unexpected byte", {23'h0, outLast, outData}, 32'h1FF);
      else chk("R2 stream byte", {23'h0, outLast, outData}, {23'h0, expQ.pop_front()});
    end
  end

  task automatic setDesc(input int a, input logic [15:0] cnt, input logic [15:0] cmd,
                         input logic [31:0] da, input logic [31:0] dep);
    mem[a/4]   = {cmd, cnt};
    mem[a/4+1] = da;
    mem[a/4+2] = dep;
    mem[a/4+3] = 32'h0000_7777;
  endtask

  task automatic writePtr(input logic [31:0] v);
    @(negedge clk); ptrWrite = 1; ptrData = v;
    @(negedge clk); ptrWrite = 0;
  endtask

  task automatic waitIdle();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3000 && chActive; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    inArr[0] = 8'hA1; inArr[1] = 8'hB2; inArr[2] = 8'hC3; inArr[3] = 8'h00;
    inIdx = 3;
    mem[32'h200/4] = 32'h4433_2211; mem[32'h204/4] = 32'h8877_6655;
    mem[32'h2D0/4] = 32'hDDCC_BBAA;
    setDesc(32'h100, 3, 16'h0000, 32'h201, 0);
    setDesc(32'h110, 2, 16'h1030, 32'h204, 0);
    setDesc(32'h120, 3, 16'h2000, 32'h281, 0);
    setDesc(32'h130, 2, 16'h4600, 32'h2C3, 32'hABCD_1234);
    setDesc(32'h140, 1, 16'h5000, 32'h2D1, 32'h0011_2233);
    setDesc(32'h150, 0, 16'h600C, 32'h0,   32'h180);
    setDesc(32'h180, 0, 16'h7000, 32'h0,   32'h0);
    setDesc(32'h300, 4, 16'h0000, 32'h0,   32'h0);
    setDesc(32'h340, 0, 16'h6019, 32'h0,   32'h380);
    setDesc(32'h350, 0, 16'h7000, 32'h0,   32'h0);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // reset state
    chk("R1 reset memReq", {31'h0, memReq}, 0);
    chk("R2 reset outValid", {31'h0, outValid}, 0);
    chk("R14 reset active", {31'h0, chActive}, 0);
    chk("R11 reset dead", {31'h0, chDead}, 0);
    chk("R12 reset ptr", cmdPtr, 0);
    chk("R8 reset irq", {31'h0, irq}, 0);

    // main chain
    writePtr(32'h100);
    chk("R12 ptr write", cmdPtr, 32'h100);
    expQ = '{9'h022, 9'h033, 9'h044, 9'h055, 9'h166};
    inIdx = 0;
    runIn = 1;
    waitIdle();
    chk("R2 all bytes sent", expQ.size(), 0);
    chk("R3 input bytes", mem[32'h280/4], 32'hC3B2_A100);
    chk("R5 store 2 bytes", mem[32'h2C0/4], 32'hABCD_0000);
    chk("R6 load 1 byte", mem[32'h148/4], 32'hBB11_2233);
    chk("R4 out status", mem[32'h10C/4], 32'h845A_0000);
    chk("R4 out-last status", mem[32'h11C/4], 32'h845A_0000);
    chk("R4 input status", mem[32'h12C/4], 32'h845A_0000);
    chk("R4 store keeps residual", mem[32'h13C/4], 32'h845A_7777);
    chk("R4 load keeps residual", mem[32'h14C/4], 32'h845A_7777);
    chk("R4 nop status", mem[32'h15C/4], 32'h845A_7777);
    chk("R7 branch target", cmdPtr, 32'h180);
    chk("R7 branch taken flag", {31'h0, chBt}, 1);
    chk("R10 stop clears active", {31'h0, chActive}, 0);
    chk("R10 stop no writeback", mem[32'h18C/4], 32'h0000_7777);
    chk("R8 one interrupt", irqCnt, 1);

    // kill on zero data address
    @(negedge clk); runIn = 0;
    writePtr(32'h300);
    @(negedge clk); runIn = 1;
    for (int i = 0; i < 200 && !chDead; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R11 dead set", {31'h0, chDead}, 1);
    chk("R11 active cleared", {31'h0, chActive}, 0);
    chk("R11 ptr kept", cmdPtr, 32'h300);
    chk("R11 kill interrupt", irqCnt, 2);

    // pointer lock while running
    writePtr(32'h340);
    chk("R12 write ignored while run", cmdPtr, 32'h300);
    @(negedge clk); runIn = 0;
    @(negedge clk);
    chk("R14 run fall clears dead", {31'h0, chDead}, 0);
    writePtr(32'h34C);
    chk("R12 aligned write", cmdPtr, 32'h340);

    // conditional wait, interrupt and branch
    waitCond = 1; intrCond = 1; branchCond = 1;
    @(negedge clk); runIn = 1;
    repeat (30) @(negedge clk);
    chk("R9 stalled active", {31'h0, chActive}, 1);
    chk("R9 stalled ptr", cmdPtr, 32'h340);
    chk("R9 no writeback", mem[32'h34C/4], 32'h0000_7777);
    waitCond = 0;
    waitIdle();
    chk("R4 status after branch flag", mem[32'h34C/4], 32'h855A_7777);
    chk("R7 ifclr not taken", cmdPtr, 32'h350);
    chk("R7 next clears flag", {31'h0, chBt}, 0);
    chk("R8 ifset interrupt", irqCnt, 3);

    // pause and wake
    setDesc(32'h350, 0, 16'h6000, 32'h0, 32'h0);
    setDesc(32'h360, 0, 16'h7000, 32'h0, 32'h0);
    pauseIn = 1;
    @(negedge clk); wakeIn = 1;
    @(negedge clk); wakeIn = 0;
    chk("R13 wake flag set", {31'h0, chWake}, 1);
    repeat (5) @(negedge clk);
    chk("R13 pause holds inactive", {31'h0, chActive}, 0);
    chk("R13 pause no fetch", cmdPtr, 32'h350);
    pauseIn = 0;
    @(negedge clk); wakeIn = 1;
    @(negedge clk); wakeIn = 0;
    waitIdle();
    chk("R13 wake cleared at fetch", mem[32'h35C/4], 32'h845A_7777);
    chk("R13 wake flag low", {31'h0, chWake}, 0);
    chk("R10 stop ptr kept", cmdPtr, 32'h360);
    chk("R1 no interrupt", irqCnt, 3);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule